// File: doc/BRIEF.md
# Multiply Unit with Product-High Accumulate

This block keeps two 16-bit registers: a multiplier register (MR) and a product-high register (PH). It executes three operations. Each operation combines the multiplier state with a data-memory word and an accumulator value that the surrounding datapath supplies. The multiply operation forms the full 32-bit product of MR and the memory word. The low half goes back as the new accumulator value, and the high half is latched into PH. The two accumulate operations load MR from the memory word in signed mode. In the same step they add PH to the accumulator, or subtract PH from it.

One operation is accepted per cycle when `op_valid` is high. The accumulator result and the carry, zero and sign flags appear on registered outputs one clock later, together with a one-cycle `res_valid` pulse. The accumulate operations read PH as it stood before the operation. A multiply followed directly by an accumulate therefore uses the upper half that this multiply produced. When the chaining bit is set, the add or subtract takes the incoming carry as carry-in or borrow-in, and the new zero flag also depends on the incoming zero flag. A chained operation still runs exactly once.

Top module: `mpy_ph_unit`

## Requirements
- R1: After reset, `mr_out`, `ph_out`, `acc_out`, `cf_out`, `zf_out`, `sf_out` and `res_valid` are all zero.
- R2: Opcode 4'b1000 with `unsigned_mode` low multiplies MR by `mem_data` as two's complement numbers. One cycle later `acc_out` holds product bits 15:0, `ph_out` holds bits 31:16, `res_valid` is high, and `mr_out` is unchanged.
- R3: Opcode 4'b1000 with `unsigned_mode` high treats both operands as unsigned, with the same result placement as R2.
- R4: After a multiply, `zf_out` is 1 exactly when the 16-bit accumulator result is zero, `sf_out` equals its bit 15, and `cf_out` is 0.
- R5: Opcode 4'b1010 loads MR from `mem_data` and gives `acc_out` = `acc_in` + PH, modulo 2^16. `cf_out` is the carry out of bit 15.
- R6: Opcode 4'b1001 loads MR from `mem_data` and gives `acc_out` = `acc_in` - PH, modulo 2^16. `cf_out` is 1 when the subtraction borrows.
- R7: The accumulate opcodes use the PH value held before the operation, and they leave PH unchanged.
- R8: With `op_string` high, opcode 4'b1010 adds `cf_in` as carry-in. With `op_string` low, `cf_in` has no effect.
- R9: With `op_string` high, opcode 4'b1001 subtracts `cf_in` as borrow-in.
- R10: For the accumulate opcodes, `zf_out` is 1 when the result is zero. With `op_string` high, `zf_in` must also be 1; with `op_string` low, `zf_in` is ignored. `sf_out` is result bit 15.
- R11: Any other opcode, or `op_valid` low, leaves MR, PH, `acc_out` and the flags unchanged and gives `res_valid` low one cycle later.
- R12: `op_string`, `cf_in` and `zf_in` have no effect on a multiply.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Operation present this cycle |
| op_code | input | 4 | Operation select (1000 multiply, 1001 load/subtract, 1010 load/add) |
| op_string | input | 1 | Chain with incoming carry and zero flags |
| unsigned_mode | input | 1 | Multiply operands taken as unsigned |
| mem_data | input | 16 | Data-memory word |
| acc_in | input | 16 | Current accumulator value |
| cf_in | input | 1 | Previous carry/borrow flag |
| zf_in | input | 1 | Previous zero flag |
| res_valid | output | 1 | Result outputs updated by the previous operation |
| acc_out | output | 16 | New accumulator value |
| cf_out | output | 1 | Carry (add) or borrow (subtract) flag |
| zf_out | output | 1 | Zero flag |
| sf_out | output | 1 | Sign flag (result bit 15) |
| mr_out | output | 16 | Current MR contents |
| ph_out | output | 16 | Current PH contents |

## Verification
The hardest case to reach is an accumulate that must see the PH value written by the multiply just before it, with no idle cycle between them. A stale-PH or write-first bug only shows up in that back-to-back order. The stimulus first loads MR through an accumulate. It then issues a multiply and, on the very next cycle, an add. The expected sum is built from the product high half computed in the bench. Chained flag behaviour is reached by driving results that are exactly zero or that wrap by exactly one. The bench then flips only `cf_in` or `zf_in`, so the outputs show whether the incoming flags were used.

// File: rtl/mpu_pkg.sv
package mpu_pkg;
  localparam int unsigned OPW = 4;

  typedef enum logic [OPW-1:0] {
    OP_MUL   = 4'b1000,
    OP_SUBPH = 4'b1001,
    OP_ADDPH = 4'b1010
  } mpu_op_e;

  typedef struct packed {
    logic cf;
    logic zf;
    logic sf;
  } mpu_flags_t;
endpackage

// File: rtl/mpu_dec.sv
module mpu_dec
  import mpu_pkg::*;
(
  input  logic           op_valid,
  input  logic [OPW-1:0] op_code,
  output logic           do_mul,
  output logic           do_acc,
  output logic           acc_sub
);
  always_comb begin
    do_mul  = 1'b0;
    do_acc  = 1'b0;
    acc_sub = 1'b0;
    if (op_valid) begin
      unique case (op_code)
        OP_MUL:   do_mul = 1'b1;
        OP_SUBPH: begin do_acc = 1'b1; acc_sub = 1'b1; end
        OP_ADDPH: do_acc = 1'b1;
        default:  ;
      endcase
    end
  end
endmodule

// File: rtl/mpu_mult.sv
module mpu_mult #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  input  logic           sgn,
  output logic [2*W-1:0] p
);
  localparam int unsigned XW = W + 1;
  localparam int unsigned PW = 2 * XW;

  logic signed [XW-1:0] ax;
  logic signed [XW-1:0] bx;
  logic signed [PW-1:0] px;

  always_comb begin
    ax = $signed({sgn & a[W-1], a});
    bx = $signed({sgn & b[W-1], b});
    px = PW'(ax) * PW'(bx);
    p  = px[2*W-1:0];
  end
endmodule

// File: rtl/mpu_addsub.sv
module mpu_addsub #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  input  logic         cin,
  output logic [W-1:0] r,
  output logic         co
);
  logic [W:0] ext;

  always_comb begin
    if (sub) ext = {1'b0, a} - {1'b0, b} - {{W{1'b0}}, cin};
    else     ext = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
    r  = ext[W-1:0];
    co = ext[W];
  end
endmodule

// File: rtl/mpy_ph_unit.sv
module mpy_ph_unit
  import mpu_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           op_valid,
  input  logic [3:0]     op_code,
  input  logic           op_string,
  input  logic           unsigned_mode,
  input  logic [W-1:0]   mem_data,
  input  logic [W-1:0]   acc_in,
  input  logic           cf_in,
  input  logic           zf_in,
  output logic           res_valid,
  output logic [W-1:0]   acc_out,
  output logic           cf_out,
  output logic           zf_out,
  output logic           sf_out,
  output logic [W-1:0]   mr_out,
  output logic [W-1:0]   ph_out
);
  localparam int unsigned PW = 2 * W;

  logic [1:0] rst_sync;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_n_s = rst_sync[1];

  logic do_mul, do_acc, acc_sub;

  mpu_dec u_dec (
    .op_valid (op_valid),
    .op_code  (op_code),
    .do_mul   (do_mul),
    .do_acc   (do_acc),
    .acc_sub  (acc_sub)
  );

  logic [W-1:0]  mr_q, ph_q, acc_q;
  logic [W-1:0]  mr_d, ph_d, acc_d;
  mpu_flags_t    fl_q, fl_d;
  logic          vld_q, vld_d, upd_en;
  logic [PW-1:0] prod;
  logic [W-1:0]  as_r;
  logic          as_co;

  mpu_mult #(.W(W)) u_mult (
    .a   (mr_q),
    .b   (mem_data),
    .sgn (~unsigned_mode),
    .p   (prod)
  );

  mpu_addsub #(.W(W)) u_addsub (
    .a   (acc_in),
    .b   (ph_q),
    .sub (acc_sub),
    .cin (op_string & cf_in),
    .r   (as_r),
    .co  (as_co)
  );

  always_comb begin
    mr_d   = mr_q;
    ph_d   = ph_q;
    acc_d  = acc_q;
    fl_d   = fl_q;
    vld_d  = do_mul | do_acc;
    upd_en = do_mul | do_acc;
    if (do_mul) begin
      acc_d   = prod[W-1:0];
      ph_d    = prod[PW-1:W];
      fl_d.cf = 1'b0;
      fl_d.zf = (prod[W-1:0] == '0);
      fl_d.sf = prod[W-1];
    end else if (do_acc) begin
      mr_d    = mem_data;
      acc_d   = as_r;
      fl_d.cf = as_co;
      fl_d.zf = (as_r == '0) & (~op_string | zf_in);
      fl_d.sf = as_r[W-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      mr_q  <= '0;
      ph_q  <= '0;
      acc_q <= '0;
      fl_q  <= '0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= vld_d;
      if (upd_en) begin
        mr_q  <= mr_d;
        ph_q  <= ph_d;
        acc_q <= acc_d;
        fl_q  <= fl_d;
      end
    end
  end

  assign res_valid = vld_q;
  assign acc_out   = acc_q;
  assign cf_out    = fl_q.cf;
  assign zf_out    = fl_q.zf;
  assign sf_out    = fl_q.sf;
  assign mr_out    = mr_q;
  assign ph_out    = ph_q;
endmodule

// File: rtl/mpy_ph_unit_chk.sv
module mpy_ph_unit_chk #(
  parameter int unsigned W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         op_valid,
  input logic [3:0]   op_code,
  input logic         op_string,
  input logic [W-1:0] mem_data,
  input logic         zf_in,
  input logic         res_valid,
  input logic [W-1:0] acc_out,
  input logic         cf_out,
  input logic         zf_out,
  input logic [W-1:0] mr_out,
  input logic [W-1:0] ph_out
);
  logic is_mul, is_acc;
  assign is_mul = op_valid && (op_code == 4'b1000);
  assign is_acc = op_valid && ((op_code == 4'b1001) || (op_code == 4'b1010));

  AST_MUL_KEEPS_MR: assert property (@(posedge clk) disable iff (!rst_n)
    is_mul |=> $stable(mr_out)); // R2
  AST_MUL_CF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    is_mul |=> (!cf_out && res_valid)); // R4
  AST_ACC_LOADS_MR: assert property (@(posedge clk) disable iff (!rst_n)
    is_acc |=> (mr_out == $past(mem_data))); // R5
  AST_ACC_KEEPS_PH: assert property (@(posedge clk) disable iff (!rst_n)
    is_acc |=> $stable(ph_out)); // R7
  AST_CHAIN_ZF: assert property (@(posedge clk) disable iff (!rst_n)
    (is_acc && op_string && !zf_in) |=> !zf_out); // R10
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_mul && !is_acc) |=> (!res_valid && $stable(acc_out) && $stable(mr_out)
                              && $stable(ph_out) && $stable(cf_out) && $stable(zf_out))); // R11
endmodule

bind mpy_ph_unit mpy_ph_unit_chk #(.W(W)) u_chk (.*);

// File: tb/mpy_ph_unit_tb.sv
`timescale 1ns/1ps
module mpy_ph_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        op_valid, op_string, unsigned_mode, cf_in, zf_in;
  logic [3:0]  op_code;
  logic [15:0] mem_data, acc_in;
  logic        res_valid, cf_out, zf_out, sf_out;
  logic [15:0] acc_out, mr_out, ph_out;

  int total = 0;
  int bad   = 0;

  always #4 clk = ~clk;

  mpy_ph_unit u_dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .op_string(op_string), .unsigned_mode(unsigned_mode), .mem_data(mem_data),
    .acc_in(acc_in), .cf_in(cf_in), .zf_in(zf_in), .res_valid(res_valid),
    .acc_out(acc_out), .cf_out(cf_out), .zf_out(zf_out), .sf_out(sf_out),
    .mr_out(mr_out), .ph_out(ph_out)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // drive on the falling edge, capture at the rising edge, check on the next falling edge
  task automatic do_op(input logic [3:0] op, input logic str, input logic uns,
                       input logic [15:0] mem, input logic [15:0] acc,
                       input logic cfi, input logic zfi);
    op_code = op; op_string = str; unsigned_mode = uns;
    mem_data = mem; acc_in = acc; cf_in = cfi; zf_in = zfi; op_valid = 1'b1;
    @(posedge clk); @(negedge clk);
    op_valid = 1'b0;
  endtask

  function automatic logic [31:0] ref_mul(input logic [15:0] a, input logic [15:0] b, input logic uns);
    longint pa, pb;
    pa = uns ? longint'(a) : longint'($signed(a));
    pb = uns ? longint'(b) : longint'($signed(b));
    return 32'(pa * pb);
  endfunction

  task automatic t_reset;
    chk("R1", "mr", {16'h0, mr_out}, 32'h0);
    chk("R1", "ph", {16'h0, ph_out}, 32'h0);
    chk("R1", "acc", {16'h0, acc_out}, 32'h0);
    chk("R1", "flags", {28'h0, res_valid, cf_out, zf_out, sf_out}, 32'h0);
  endtask

  task automatic t_mul_signed;
    logic [31:0] p;
    do_op(4'b1010, 1'b0, 1'b0, 16'hFFFD, 16'h0000, 1'b0, 1'b0); // MR = -3
    chk("R5", "mr load", {16'h0, mr_out}, 32'h0000FFFD);
    p = ref_mul(16'hFFFD, 16'd1000, 1'b0);
    do_op(4'b1000, 1'b0, 1'b0, 16'd1000, 16'h1234, 1'b0, 1'b0);
    chk("R2", "acc low", {16'h0, acc_out}, {16'h0, p[15:0]});
    chk("R2", "ph high", {16'h0, ph_out}, {16'h0, p[31:16]});
    chk("R2", "mr kept", {16'h0, mr_out}, 32'h0000FFFD);
    chk("R4", "flags c/z/s", {29'h0, cf_out, zf_out, sf_out}, {29'h0, 1'b0, 1'b0, p[15]});
    chk("R2", "res_valid", {31'h0, res_valid}, 32'h1);
  endtask

  task automatic t_mul_unsigned;
    logic [31:0] p;
    p = ref_mul(16'hFFFD, 16'd1000, 1'b1);
    do_op(4'b1000, 1'b0, 1'b1, 16'd1000, 16'h0, 1'b0, 1'b0);
    chk("R3", "acc low", {16'h0, acc_out}, {16'h0, p[15:0]});
    chk("R3", "ph high", {16'h0, ph_out}, {16'h0, p[31:16]});
    // zero low half with nonzero high; chaining inputs set (R12)
    do_op(4'b1010, 1'b0, 1'b0, 16'h0100, 16'h0, 1'b0, 1'b0);
    do_op(4'b1000, 1'b1, 1'b1, 16'h0200, 16'h0, 1'b1, 1'b0);
    chk("R4", "zero low", {29'h0, cf_out, zf_out, sf_out}, 32'h2);
    chk("R12", "acc ignores chain", {16'h0, acc_out}, 32'h0);
    chk("R12", "ph", {16'h0, ph_out}, 32'h0002);
  endtask

  task automatic t_accumulate;
    logic [31:0] p;
    logic [16:0] s;
    // back-to-back: multiply then add must see the fresh PH
    do_op(4'b1010, 1'b0, 1'b0, 16'h7FFF, 16'h0, 1'b0, 1'b0);
    p = ref_mul(16'h7FFF, 16'h7FFF, 1'b0);
    op_code = 4'b1000; op_string = 1'b0; unsigned_mode = 1'b0;
    mem_data = 16'h7FFF; acc_in = 16'h0; cf_in = 1'b0; zf_in = 1'b0; op_valid = 1'b1;
    @(posedge clk); @(negedge clk);
    op_code = 4'b1010; mem_data = 16'h0055; acc_in = 16'hF000;
    @(posedge clk); @(negedge clk);
    op_valid = 1'b0;
    s = {1'b0, 16'hF000} + {1'b0, p[31:16]};
    chk("R7", "add old ph", {16'h0, acc_out}, {16'h0, s[15:0]});
    chk("R5", "carry", {31'h0, cf_out}, {31'h0, s[16]});
    chk("R7", "ph kept", {16'h0, ph_out}, {16'h0, p[31:16]});
    chk("R5", "mr", {16'h0, mr_out}, 32'h0055);
    // subtract with borrow: acc < PH (PH = 0x3FFF)
    do_op(4'b1001, 1'b0, 1'b0, 16'h0011, 16'h0001, 1'b1, 1'b1);
    chk("R6", "diff", {16'h0, acc_out}, {16'h0, 16'(16'h0001 - p[31:16])});
    chk("R6", "borrow", {31'h0, cf_out}, 32'h1);
    chk("R10", "sign", {31'h0, sf_out}, 32'h1);
    chk("R6", "mr", {16'h0, mr_out}, 32'h0011);
  endtask

  task automatic t_chain;
    // PH = 0x3FFF from the previous multiply
    do_op(4'b1010, 1'b1, 1'b0, 16'h0, 16'hC000, 1'b1, 1'b1);
    chk("R8", "carry-in wraps", {16'h0, acc_out}, 32'h0);
    chk("R10", "zf chain set", {30'h0, cf_out, zf_out}, 32'h3);
    do_op(4'b1010, 1'b1, 1'b0, 16'h0, 16'hC000, 1'b1, 1'b0);
    chk("R10", "zf chain blocked", {31'h0, zf_out}, 32'h0);
    do_op(4'b1010, 1'b0, 1'b0, 16'h0, 16'hC000, 1'b1, 1'b0);
    chk("R8", "no chain", {16'h0, acc_out}, 32'hFFFF);
    chk("R10", "zf_in ignored", {31'h0, zf_out}, 32'h0);
    do_op(4'b1001, 1'b1, 1'b0, 16'h0, 16'h4000, 1'b1, 1'b1);
    chk("R9", "borrow-in", {16'h0, acc_out}, 32'h0);
    chk("R9", "zf/cf", {30'h0, cf_out, zf_out}, 32'h1);
    do_op(4'b1001, 1'b0, 1'b0, 16'h0, 16'h4000, 1'b1, 1'b1);
    chk("R9", "no borrow-in", {16'h0, acc_out}, 32'h0001);
  endtask

  task automatic t_ignore;
    logic [15:0] a0, m0, p0;
    a0 = acc_out; m0 = mr_out; p0 = ph_out;
    do_op(4'b0101, 1'b1, 1'b0, 16'hAAAA, 16'h5555, 1'b1, 1'b1);
    chk("R11", "bad op valid", {31'h0, res_valid}, 32'h0);
    chk("R11", "bad op acc", {16'h0, acc_out}, {16'h0, a0});
    chk("R11", "bad op mr/ph", {mr_out, ph_out}, {m0, p0});
    op_code = 4'b1000; mem_data = 16'h1111; op_valid = 1'b0;
    @(posedge clk); @(negedge clk);
    chk("R11", "idle state", {mr_out, ph_out}, {m0, p0});
    chk("R11", "idle acc", {16'h0, acc_out}, {16'h0, a0});
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; op_valid = 1'b0; op_code = 4'h0; op_string = 1'b0;
    unsigned_mode = 1'b0; mem_data = '0; acc_in = '0; cf_in = 1'b0; zf_in = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_mul_signed();
    t_mul_unsigned();
    t_accumulate();
    t_chain();
    t_ignore();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule